// File: doc/BRIEF.md
# Level-Sensitive DMA Request Sequencer

This block arbitrates level-type transfer requests for a four-channel DMA engine. Each channel has its own request wire and a polarity setting that picks whether high or low means "request". The request levels are sampled on every rising clock edge while all channels are waiting. When one or more are active, the block claims the bus, selects the lowest-numbered active channel and drives that channel's acknowledge wire to its active level. It also reports the channel index and the byte count of the unit to be moved.

While a unit is in flight the requests are not looked at. The engine signals the end of a unit with a one-cycle completion pulse. On that edge the request levels are sampled once more, and that sample alone decides what happens next. The block either runs another unit on the same channel, moves to a higher-priority channel, moves to any other active channel, or drops its bus claim and goes back to waiting.

Top module: `dma_level_req_seq`

## Requirements
- R1: During and right after synchronous reset the bus request is low and every acknowledge wire sits at its inactive level, whatever the request inputs do.
- R2: While waiting, a request sampled active at a rising edge raises the bus request and starts a transfer on that channel from the next cycle.
- R3: A channel's request is active when its level equals its polarity bit: polarity 1 means active-high, polarity 0 means active-low.
- R4: A channel's acknowledge equals its polarity bit while that channel is in transfer, and equals the inverse of that bit otherwise.
- R5: At a completion edge, if the current channel's request is still active and no lower-numbered channel is active, the same channel runs its next unit at once, with no gap in the bus request or the acknowledge.
- R6: At a completion edge, an active request on a lower-numbered channel than the current one wins, and the block switches to it.
- R7: At a completion edge with no request active, the bus request drops and all channels return to waiting.
- R8: At a completion edge where the current request is inactive but another channel's request is active, the block moves to the lowest-numbered such channel.
- R9: The unit-size output gives 1, 2, 4 or 16 bytes for size codes 0, 1, 2 and 3 of the current channel. The code of channel n is in bits [2n+1:2n] of the size-select input.
- R10: A request that is active only between clock edges, and is inactive at the sampling edge while waiting, is never serviced. A completion pulse while waiting has no effect.
- R11: While a unit is in flight and no completion pulse arrives, changes on the request inputs do not change the current channel or the bus request.
- R12: When several requests are found active at the same time while waiting, channel 0 has the highest priority and channel 3 the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq_i | input | NCH | Per-channel request levels |
| req_pol_i | input | NCH | Per-channel active level (1 = high) |
| unit_sel_i | input | 2*NCH | Per-channel 2-bit transfer-unit code |
| done_i | input | 1 | One-cycle completion pulse for the unit in flight |
| bus_req_o | output | 1 | Bus ownership claim, high during transfer |
| dack_o | output | NCH | Per-channel acknowledge, polarity per req_pol_i |
| chan_o | output | CW | Index of the channel in transfer |
| unit_bytes_o | output | 5 | Byte count of the current unit |

## Verification
The bench builds the block with its default of four channels and uses a mixed polarity pattern: channels 0 and 2 are active-high and channels 1 and 3 active-low. Each channel gets a different size code. With this setup one run covers both request polarities, all four size codes, and every direction of hand-over at a completion edge: staying on the same channel, moving up in priority, and moving down in priority. It also covers the glitch case, where a request is raised and dropped between two edges.

// File: rtl/dma_level_req_seq.sv
module dma_level_req_seq #(
  parameter int NCH = 4,
  localparam int SZW = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       dreq_i,
  input  logic [NCH-1:0]       req_pol_i,
  input  logic [NCH*SZW-1:0]   unit_sel_i,
  input  logic                 done_i,
  output logic                 bus_req_o,
  output logic [NCH-1:0]       dack_o,
  output logic [CW-1:0]        chan_o,
  output logic [4:0]           unit_bytes_o
);

  logic           busy;
  logic [CW-1:0]  cur;
  logic [NCH-1:0] act;
  logic           any_act;
  logic [CW-1:0]  win;
  logic           higher;

  assign act     = ~(dreq_i ^ req_pol_i);
  assign any_act = |act;

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (act[i]) win = CW'(i);
  end

  always_comb begin
    higher = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (act[i] && CW'(i) < cur) higher = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (!busy || done_i) begin
      busy <= any_act;
      if (any_act) cur <= win;
    end
  end

  assign bus_req_o = busy;
  assign chan_o    = cur;

  logic [SZW-1:0] code;
  assign code = unit_sel_i[cur*SZW +: SZW];

  always_comb begin
    case (code)
      2'd0:    unit_bytes_o = 5'd1;
      2'd1:    unit_bytes_o = 5'd2;
      2'd2:    unit_bytes_o = 5'd4;
      default: unit_bytes_o = 5'd16;
    endcase
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    assign dack_o[g] = (busy && cur == CW'(g)) ? req_pol_i[g] : ~req_pol_i[g];
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    !busy && any_act |=> bus_req_o);

  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (rst)
    !busy && !any_act |=> !bus_req_o);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    busy && !done_i |=> bus_req_o && $stable(chan_o));

  assert_continue_R5: assert property (@(posedge clk) disable iff (rst)
    busy && done_i && act[cur] && !higher |=> bus_req_o && chan_o == $past(chan_o));

  assert_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    busy && done_i && higher |=> bus_req_o && chan_o < $past(chan_o));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    busy && done_i && !any_act |=> !bus_req_o);

endmodule

// File: tb/dma_level_req_seq_tb_top.sv
module dma_level_req_seq_tb_top;

  localparam int NCH = 4;
  localparam logic [3:0] POL = 4'b0101;
  localparam logic [7:0] SIZES = {2'd3, 2'd2, 2'd1, 2'd0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dreq;
  logic       done = 1'b0;
  logic       bus_req;
  logic [3:0] dack;
  logic [1:0] chan;
  logic [4:0] ubytes;

  always #5 clk = ~clk;

  dma_level_req_seq #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .dreq_i(dreq), .req_pol_i(POL),
    .unit_sel_i(SIZES), .done_i(done), .bus_req_o(bus_req),
    .dack_o(dack), .chan_o(chan), .unit_bytes_o(ubytes)
  );

  typedef struct {
    logic       busy;
    logic [1:0] ch;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [3:0] lvl(logic [3:0] mask);
    return ~(mask ^ POL);
  endfunction

  function automatic logic [4:0] bytes_of(logic [1:0] ch);
    case (SIZES[ch*2 +: 2])
      2'd0: return 5'd1;
      2'd1: return 5'd2;
      2'd2: return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  task automatic cyc(logic r, logic [3:0] mask, logic d, logic eb, logic [1:0] ech,
                     string req, bit glitch = 0);
    exp_t e;
    @(negedge clk);
    rst  = r;
    dreq = lvl(mask);
    done = d;
    if (glitch) begin
      #2 dreq = lvl(4'b0000);
    end
    e.busy = eb; e.ch = ech; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        logic [3:0] edack;
        e = q.pop_front();
        edack = ~POL;
        if (e.busy) edack[e.ch] = POL[e.ch];
        chk(e.req, "bus_req", int'(bus_req), int'(e.busy));
        chk(e.req, "dack(R4)", int'(dack), int'(edack));
        if (e.busy) begin
          chk(e.req, "chan", int'(chan), int'(e.ch));
          chk(e.req, "bytes(R9)", int'(ubytes), int'(bytes_of(e.ch)));
        end
      end
    end
  end

  initial begin
    dreq = lvl(4'b0000);
    cyc(1, 4'b0000, 0, 0, 0, "R1");
    cyc(1, 4'b1111, 0, 0, 0, "R1");
    cyc(0, 4'b0000, 0, 0, 0, "R1");
    cyc(0, 4'b0010, 0, 0, 0, "R10 glitch", 1);
    cyc(0, 4'b0000, 1, 0, 0, "R10 done-idle");
    cyc(0, 4'b0010, 0, 1, 1, "R2 R3 active-low start");
    cyc(0, 4'b0011, 0, 1, 1, "R11 hold");
    cyc(0, 4'b1111, 0, 1, 1, "R11 hold");
    cyc(0, 4'b0011, 1, 1, 0, "R6 preempt");
    cyc(0, 4'b0011, 1, 1, 0, "R5 continue");
    cyc(0, 4'b1000, 1, 1, 3, "R8 move down");
    cyc(0, 4'b1100, 0, 1, 3, "R11 hold");
    cyc(0, 4'b1100, 1, 1, 2, "R6 preempt");
    cyc(0, 4'b0000, 1, 0, 0, "R7 release");
    cyc(0, 4'b0100, 0, 1, 2, "R3 active-high start");
    cyc(0, 4'b0100, 1, 1, 2, "R5 continue");
    cyc(0, 4'b0000, 1, 0, 0, "R7 release");
    cyc(0, 4'b1111, 0, 1, 0, "R12 priority");
    cyc(0, 4'b1110, 1, 1, 1, "R8 move down");
    cyc(0, 4'b0000, 1, 0, 0, "R7 release");
    cyc(1, 4'b1111, 0, 0, 0, "R1 reset mid-run");
    repeat (3) @(negedge clk);
    chk("R1", "queue drained", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule